// File: doc/BRIEF.md
# Three-Multiplier Complex FIR Filter

This block filters a stream of complex samples with a fixed set of complex taps. It does not use four real filters with cross-coupled sums. It uses three real filters that run side by side on every accepted sample:

- **Shared path:** one filter sees the sum of the real and imaginary inputs and applies the real tap parts.
- **Imaginary-input path:** one filter sees only the imaginary input and applies the per-tap sum of the real and imaginary tap parts.
- **Real-input path:** one filter sees only the real input and applies the per-tap difference, imaginary part minus real part.

A registered combining stage forms the two outputs:

- The real output is the shared result minus the imaginary-input result.
- The imaginary output is the shared result plus the real-input result.

The taps are fixed at elaboration through parameters. A sample is accepted on any cycle with `in_valid` high. Each accepted sample produces exactly one complex output two cycles later. The datapath keeps full precision, so no result is ever rounded or wrapped.

Top module: `cfir_three_mult`

## Requirements
- R1: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` is high, and low otherwise.
- R2: For each accepted sample n, `out_re` equals the sum over taps k of hr[k]·xr[n−k] − hi[k]·xi[n−k]. Here tap k applies to the k-th most recent accepted sample, with k = 0 the current one. The result is bit-exact, two's complement, and `OW` bits wide.
- R3: For each accepted sample n, `out_im` equals the sum over taps k of hr[k]·xi[n−k] + hi[k]·xr[n−k]. It is bit-exact in the same encoding as R2.
- R4: A cycle with `in_valid` low does not advance the sample history. `out_re` and `out_im` keep the values of the last output.
- R5: A synchronous active-high `rst` clears the sample history, `out_valid`, `out_re` and `out_im` to zero. The first outputs after reset use zero history.
- R6: Full-scale inputs produce correct results, including the most negative value on both components. The top two bits of each output are always equal, so no overflow is possible.
- R7: Tap k of the real parts is `COEF_RE[k*CW +: CW]`, and tap k of the imaginary parts is `COEF_IM[k*CW +: CW]`. Both are signed two's complement. An impulse of 1 on the real input therefore reproduces the taps in order, one per accepted sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample is accepted this cycle |
| in_re | input | DW | Real input component, signed |
| in_im | input | DW | Imaginary input component, signed |
| out_valid | output | 1 | Output sample is valid this cycle |
| out_re | output | OW | Real output, signed, OW = DW+CW+2+clog2(TAPS) |
| out_im | output | OW | Imaginary output, signed |

## Verification
The assertions assume the following about the inputs:
- Input samples and taps are signed two's complement values of `DW` and `CW` bits.
- `in_valid` is a clean level that is sampled once per clock.

Under these assumptions, the output width leaves one redundant sign bit whatever the data, even at the most negative input and tap values. The stimulus keeps within these assumptions:
- Random samples are drawn from the full `DW`-bit range.
- Valid gaps are inserted at random.
- Directed runs drive the extreme values.
- A reset is applied in the middle of the run, so the history is cleared mid-stream.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
  // Width of one real-filter accumulator: widened operand product plus tap growth.
  function automatic int fir_acc_width(int dw, int cw, int taps);
    return dw + cw + 1 + $clog2(taps);
  endfunction

  // Width of the combined output: one more bit for the final add/subtract.
  function automatic int cfir_out_width(int dw, int cw, int taps);
    return fir_acc_width(dw, cw, taps) + 1;
  endfunction
endpackage

// File: rtl/cfir_presum.sv
module cfir_presum #(
  parameter int DW = 12
) (
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic signed [DW:0]   sum
);
  // One bit of growth keeps the sum exact for every input pair.
  assign sum = {a[DW-1], a} + {b[DW-1], b};
endmodule

// File: rtl/cfir_real_fir.sv
module cfir_real_fir #(
  parameter int IW   = 13,
  parameter int KW   = 13,
  parameter int TAPS = 4,
  parameter int AW   = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [IW-1:0]     sample,
  input  logic [TAPS*KW-1:0]       coefs,
  output logic                     out_valid,
  output logic signed [AW-1:0]     acc
);
  // Delay line holds the previous TAPS-1 accepted samples.
  logic signed [IW-1:0] hist [1:TAPS-1];
  logic signed [IW-1:0] tap_in [TAPS];
  logic signed [AW-1:0] prod [TAPS];
  logic signed [AW-1:0] sum_c;

  assign tap_in[0] = sample;

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    wire signed [KW-1:0] ck = coefs[k*KW +: KW];
    if (k > 0) begin : g_hist
      assign tap_in[k] = hist[k];
    end
    // Sign-extend both operands to AW bits. The true product fits, so truncation is exact.
    assign prod[k] = AW'(tap_in[k]) * AW'(ck);
  end

  always_comb begin
    sum_c = '0;
    for (int k = 0; k < TAPS; k++) begin
      sum_c = sum_c + prod[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k < TAPS; k++) hist[k] <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        hist[1] <= sample;
        for (int k = 2; k < TAPS; k++) hist[k] <= hist[k-1];
        acc <= sum_c;
      end
    end
  end
endmodule

// File: rtl/cfir_combine.sv
module cfir_combine #(
  parameter int AW = 28,
  parameter int OW = 29
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [AW-1:0] shared_acc,
  input  logic signed [AW-1:0] im_path_acc,
  input  logic signed [AW-1:0] re_path_acc,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_re <= OW'(shared_acc) - OW'(im_path_acc);
        out_im <= OW'(shared_acc) + OW'(re_path_acc);
      end
    end
  end
endmodule

// File: rtl/cfir_three_mult.sv
module cfir_three_mult
  import cfir_pkg::*;
#(
  parameter int DW   = 12,
  parameter int CW   = 12,
  parameter int TAPS = 4,
  parameter logic [TAPS*CW-1:0] COEF_RE = 48'hF9C_123_800_7FF,
  parameter logic [TAPS*CW-1:0] COEF_IM = 48'h7FF_E00_0C8_800,
  localparam int AW = fir_acc_width(DW, CW, TAPS),
  localparam int OW = cfir_out_width(DW, CW, TAPS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_re,
  output logic signed [OW-1:0] out_im
);
  localparam int KW = CW + 1;

  // Derived tap sets, each one bit wider than a tap part.
  logic [TAPS*KW-1:0] k_sum;   // hr + hi
  logic [TAPS*KW-1:0] k_diff;  // hi - hr

  for (genvar k = 0; k < TAPS; k++) begin : g_coef
    wire signed [CW-1:0] hr = COEF_RE[k*CW +: CW];
    wire signed [CW-1:0] hi = COEF_IM[k*CW +: CW];
    assign k_sum[k*KW +: KW]  = KW'(hr) + KW'(hi);
    assign k_diff[k*KW +: KW] = KW'(hi) - KW'(hr);
  end

  logic signed [DW:0]   xsum;
  logic signed [AW-1:0] acc_shared, acc_im_path, acc_re_path;
  logic                 v_shared, v_im_path, v_re_path;

  cfir_presum #(.DW(DW)) presum_i (
    .a(in_re), .b(in_im), .sum(xsum)
  );

  cfir_real_fir #(.IW(DW+1), .KW(CW), .TAPS(TAPS), .AW(AW)) fir_shared_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sample(xsum),
    .coefs(COEF_RE), .out_valid(v_shared), .acc(acc_shared)
  );

  cfir_real_fir #(.IW(DW), .KW(KW), .TAPS(TAPS), .AW(AW)) fir_im_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sample(in_im),
    .coefs(k_sum), .out_valid(v_im_path), .acc(acc_im_path)
  );

  cfir_real_fir #(.IW(DW), .KW(KW), .TAPS(TAPS), .AW(AW)) fir_re_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sample(in_re),
    .coefs(k_diff), .out_valid(v_re_path), .acc(acc_re_path)
  );

  // All three paths share one latency, so any one valid drives the combiner.
  logic unused_v;
  assign unused_v = v_im_path ^ v_re_path;

  cfir_combine #(.AW(AW), .OW(OW)) combine_i (
    .clk(clk), .rst(rst), .in_valid(v_shared),
    .shared_acc(acc_shared), .im_path_acc(acc_im_path), .re_path_acc(acc_re_path),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );
endmodule

// File: rtl/cfir_three_mult_chk.sv
module cfir_three_mult_chk #(
  parameter int DW = 12,
  parameter int OW = 29
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic signed [DW-1:0] in_re,
  input logic signed [DW-1:0] in_im,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_re,
  input logic signed [OW-1:0] out_im
);
  logic v1, v2;
  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
    end
  end

  logic unused_in;
  assign unused_in = ^{in_re, in_im};

  // R1: output valid trails input valid by two cycles.
  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == v2);

  // R4: with no sample one cycle earlier, the outputs hold.
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !v1 |=> ($stable(out_re) && $stable(out_im)));

  // R5: reset clears the output valid.
  assert_reset_R5: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R6: the top two output bits never differ, so there is no overflow.
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_re[OW-1] == out_re[OW-2]) && (out_im[OW-1] == out_im[OW-2]));
endmodule

bind cfir_three_mult cfir_three_mult_chk #(.DW(DW), .OW(OW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
  .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
);

// File: tb/cfir_three_mult_tb_top.sv
`timescale 1ns/1ps
module cfir_three_mult_tb_top;
  localparam int DW   = 12;
  localparam int CW   = 12;
  localparam int TAPS = 4;
  localparam logic [TAPS*CW-1:0] CRE = 48'hF9C_123_800_7FF;
  localparam logic [TAPS*CW-1:0] CIM = 48'h7FF_E00_0C8_800;
  localparam int OW = DW + CW + 2 + $clog2(TAPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [OW-1:0] out_re, out_im;

  always #4 clk = ~clk;  // 125 MHz

  cfir_three_mult #(.DW(DW), .CW(CW), .TAPS(TAPS), .COEF_RE(CRE), .COEF_IM(CIM)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im)
  );

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string tag = "R2/R3";

  longint hx_re [TAPS];
  longint hx_im [TAPS];
  bit     p1_v, p2_v;
  longint p1_re, p1_im, p2_re, p2_im, last_re, last_im;

  function automatic longint coef(input logic [TAPS*CW-1:0] v, input int k);
    logic signed [CW-1:0] c;
    c = v[k*CW +: CW];
    return longint'(c);
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < TAPS; k++) begin hx_re[k] = 0; hx_im[k] = 0; end
    p1_v = 0; p2_v = 0; p1_re = 0; p1_im = 0; p2_re = 0; p2_im = 0;
    last_re = 0; last_im = 0;
  endtask

  task automatic check_outputs();
    chk("R1 out_valid", longint'(out_valid), longint'(p2_v));
    if (p2_v) begin
      chk({tag, " out_re"}, longint'(out_re), p2_re);
      chk({tag, " out_im"}, longint'(out_im), p2_im);
      last_re = p2_re; last_im = p2_im;
    end else begin
      chk("R4 hold out_re", longint'(out_re), last_re);
      chk("R4 hold out_im", longint'(out_im), last_im);
    end
  endtask

  task automatic step(input bit v, input longint re, input longint im);
    longint er, ei;
    @(negedge clk);
    check_outputs();
    in_valid = v;
    in_re = DW'(re);
    in_im = DW'(im);
    er = 0; ei = 0;
    if (v) begin
      for (int k = TAPS-1; k > 0; k--) begin hx_re[k] = hx_re[k-1]; hx_im[k] = hx_im[k-1]; end
      hx_re[0] = longint'(in_re);
      hx_im[0] = longint'(in_im);
      for (int k = 0; k < TAPS; k++) begin
        er += coef(CRE, k) * hx_re[k] - coef(CIM, k) * hx_im[k];
        ei += coef(CRE, k) * hx_im[k] + coef(CIM, k) * hx_re[k];
      end
    end
    p2_v = p1_v; p2_re = p1_re; p2_im = p1_im;
    p1_v = v; p1_re = er; p1_im = ei;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R5 reset out_valid", longint'(out_valid), 0);
    chk("R5 reset out_re", longint'(out_re), 0);
    chk("R5 reset out_im", longint'(out_im), 0);
    clear_model();
    rst = 1'b0;
  endtask

  localparam longint MINV = -(64'sd1 <<< (DW-1));
  localparam longint MAXV = (64'sd1 <<< (DW-1)) - 1;

  initial begin
    void'($urandom(32'hC0F1_3A57));
    clear_model();
    do_reset();

    // R7: real impulse reproduces taps in order, with a gap to show R4.
    tag = "R7 impulse";
    step(1, 1, 0);
    step(0, 0, 0);
    for (int i = 0; i < TAPS + 2; i++) step(1, 0, 0);
    // Imaginary impulse.
    step(1, 0, 1);
    for (int i = 0; i < TAPS + 1; i++) step(1, 0, 0);

    // R6: full-scale patterns, including the most negative value on both parts.
    tag = "R6 full-scale";
    for (int i = 0; i < 2*TAPS; i++) step(1, MINV, MINV);
    for (int i = 0; i < 2*TAPS; i++) step(1, MAXV, MINV);
    for (int i = 0; i < 2*TAPS; i++) step(1, (i % 2) ? MAXV : MINV, (i % 2) ? MINV : MAXV);
    for (int i = 0; i < 2*TAPS; i++) step(1, MINV, MAXV);

    // R5: reset mid-stream, then zero history on restart.
    step(1, 100, -200);
    step(1, -300, 400);
    do_reset();
    tag = "R5 after reset";
    step(1, 7, -9);
    step(1, 0, 0);
    step(0, 0, 0);
    step(0, 0, 0);

    // R2/R3/R4: random samples with random valid gaps.
    tag = "R2/R3 random";
    for (int i = 0; i < 4000; i++) begin
      logic signed [DW-1:0] r, m;
      bit v;
      r = DW'($urandom);
      m = DW'($urandom);
      v = ($urandom % 4) != 0;
      step(v, longint'(r), longint'(m));
    end
    for (int i = 0; i < 4; i++) step(0, 0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule